// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Write Port

This block holds a 256-entry colour lookup table. Each entry is made of separate 8-bit red, green and blue parts. A bus master loads the table through a small register window. It first writes a starting entry number to an index register. It then writes the colour components one after another to a single data register. An internal phase counter decides which colour plane each data write lands in. Once the third component of an entry has been written, the entry number steps forward on its own. A whole palette can therefore be streamed after one index write.

The pixel pipeline reads the table through a separate lookup port. It presents an 8-bit entry number and gets the packed 24-bit colour back on the next clock. After reset the table reads as black everywhere except the last entry, which reads as full white. This reset content is produced without sweeping the storage, so the storage itself can map onto block RAM.

Top module: `clut_dac`

## Requirements
- R1: After reset, a lookup of any entry 0..254 returns 24'h000000 and a lookup of entry 255 returns 24'hFFFFFF.
- R2: An accepted write to byte offset 0x0 loads the index from wdata[31:24] and returns the phase to red, even if a triple was half written.
- R3: Accepted writes to byte offset 0x4 store wdata[31:24] into red, then green, then blue of the current entry. Bits 23:0 of the write data have no effect.
- R4: The write that stores blue advances the index by one and returns the phase to red, so the following data write goes to red of the next entry.
- R5: A write or read is accepted only when be is 4'hF and addr[1:0] is 0. Rejected accesses, and writes to offsets 0x8 and 0xC, change neither the table, the index nor the phase.
- R6: An accepted read raises rvalid for exactly one cycle, on the cycle after the request, with rdata equal to zero. A rejected read raises no rvalid.
- R7: The lookup port returns {red, green, blue} of the entry on lk_idx, with red in bits 23:16 and blue in bits 7:0, one clock after lk_idx is sampled.
- R8: A component that has not been written since reset keeps its reset value, even when the other components of the same entry have been written.
- R9: A lookup of an entry in the same cycle as a write to that entry returns the value from before the write. The new value appears on the lookup one cycle later.
- R10: The index wraps from 255 to 0 after the blue write to entry 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 4 | Byte address within the 16-byte window |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data; the byte used is bits 31:24 |
| bus_rvalid | output | 1 | Read response strobe, one cycle after an accepted read |
| bus_rdata | output | 32 | Read data, always zero |
| lk_idx | input | 8 | Lookup entry number |
| lk_rgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
The hardest situation to reach is a partly written entry next to untouched ones. Examples are an entry whose red alone has changed after reset, or entry 255 with only one component overwritten. The storage is not cleared at reset, so only the per-component written flags make these read back correctly. The bench reaches these states in three ways. It issues a reset in the middle of the run and writes single components. It abandons a triple by rewriting the index. It places a lookup in the very cycle of the blue write so that the old-then-new order shows up at the lookup port.

// File: rtl/clut_pkg.sv
package clut_pkg;
  // Component phase, one-hot: bit 0 red, bit 1 green, bit 2 blue
  typedef enum logic [2:0] {
    PH_RED   = 3'b001,
    PH_GREEN = 3'b010,
    PH_BLUE  = 3'b100
  } phase_t;

  localparam int unsigned NUM_PLANES = 3;
endpackage

// File: rtl/clut_bus_decode.sv
module clut_bus_decode #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COMP_W = 8
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              idx_wr,
  output logic              dat_wr,
  output logic              rd_ok,
  output logic [COMP_W-1:0] wr_byte
);
  localparam int unsigned LANE_W = $clog2(DATA_W/8);
  localparam int unsigned WORD_W = ADDR_W - LANE_W;

  logic              legal;
  logic [WORD_W-1:0] word;
  logic              unused_low;

  assign word       = bus_addr[ADDR_W-1:LANE_W];
  assign legal      = (bus_be == '1) && (bus_addr[LANE_W-1:0] == '0);
  assign idx_wr     = bus_wr && legal && (word == WORD_W'(0));
  assign dat_wr     = bus_wr && legal && (word == WORD_W'(1));
  assign rd_ok      = bus_rd && legal;
  assign wr_byte    = bus_wdata[DATA_W-1 -: COMP_W];
  assign unused_low = ^bus_wdata[DATA_W-COMP_W-1:0];
endmodule

// File: rtl/clut_sequencer.sv
module clut_sequencer
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_wr,
  input  logic              dat_wr,
  input  logic [COMP_W-1:0] wr_byte,
  output logic [NUM_PLANES-1:0] plane_we,
  output logic [IDX_W-1:0]  wr_addr
);
  phase_t           phase;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_RED;
      idx   <= '0;
    end else if (idx_wr) begin
      phase <= PH_RED;
      idx   <= IDX_W'(wr_byte);
    end else if (dat_wr) begin
      unique case (phase)
        PH_RED:   phase <= PH_GREEN;
        PH_GREEN: phase <= PH_BLUE;
        default: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
      endcase
    end
  end

  assign plane_we = dat_wr ? phase : '0;
  assign wr_addr  = idx;

  assert_phase_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot(phase));

  assert_index_load_R2: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> (idx == IDX_W'($past(wr_byte))) && (phase == PH_RED));

  assert_advance_after_blue_R4: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && !idx_wr && phase == PH_BLUE) |=>
      (idx == $past(idx) + 1'b1) && (phase == PH_RED));

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!dat_wr && !idx_wr) |=> $stable(idx) && $stable(phase));
endmodule

// File: rtl/clut_plane.sv
module clut_plane #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [COMP_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [COMP_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  // Storage without reset so that it maps onto block RAM
  logic [COMP_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [COMP_W-1:0] mem_q;
  logic              written_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      written_q <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      if (we) written[waddr] <= 1'b1;
      written_q <= written[raddr];
      last_q    <= (raddr == IDX_W'(DEPTH - 1));
    end
  end

  // Unwritten components read as the reset content: all ones on the last entry
  assign rdata = written_q ? mem_q : (last_q ? '1 : '0);

  assert_flag_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    we |=> written[$past(waddr)]);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    written[raddr] |=> $past(written[raddr]) ? written[$past(raddr)] : 1'b1);
endmodule

// File: rtl/clut_dac.sv
module clut_dac
  import clut_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned IDX_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W/8-1:0]  bus_be,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic                 bus_rvalid,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [IDX_W-1:0]     lk_idx,
  output logic [NUM_PLANES*COMP_W-1:0] lk_rgb
);
  logic                  idx_wr;
  logic                  dat_wr;
  logic                  rd_ok;
  logic [COMP_W-1:0]     wr_byte;
  logic [NUM_PLANES-1:0] plane_we;
  logic [IDX_W-1:0]      wr_addr;

  clut_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COMP_W(COMP_W)
  ) u_decode (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .idx_wr(idx_wr), .dat_wr(dat_wr), .rd_ok(rd_ok),
    .wr_byte(wr_byte)
  );

  clut_sequencer #(
    .IDX_W(IDX_W), .COMP_W(COMP_W)
  ) u_seq (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .dat_wr(dat_wr), .wr_byte(wr_byte),
    .plane_we(plane_we), .wr_addr(wr_addr)
  );

  // Plane 0 is red and lands in the top byte of the lookup result
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    clut_plane #(
      .IDX_W(IDX_W), .COMP_W(COMP_W)
    ) u_plane (
      .clk(clk), .rst(rst), .we(plane_we[p]), .waddr(wr_addr),
      .wdata(wr_byte), .raddr(lk_idx),
      .rdata(lk_rgb[(NUM_PLANES-1-p)*COMP_W +: COMP_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_ok;
      bus_rdata  <= '0;
    end
  end

  assert_single_plane_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(plane_we));

  assert_reject_partial_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_be != '1) |-> (plane_we == '0));

  assert_read_response_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_be == '1 && bus_addr[1:0] == 2'b00) |=> bus_rvalid);
endmodule

// File: tb/clut_dac_test.sv
module clut_dac_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [7:0]  lk_idx;
  logic [23:0] lk_rgb;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clut_dac uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  function automatic logic [7:0] fr(int i); return 8'((i * 7 + 3) & 255); endfunction
  function automatic logic [7:0] fg(int i); return 8'(i) ^ 8'h5A; endfunction
  function automatic logic [7:0] fb(int i); return 8'(255 - i); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    bus_be = 4'hF; bus_wdata = '0; lk_idx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic look(input logic [7:0] i, output logic [23:0] v);
    @(negedge clk);
    lk_idx = i;
    @(negedge clk);
    v = lk_rgb;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    int errs;
    rst = 1'b1;
    do_reset();

    // R1: reset contents, full sweep
    errs = 0;
    for (int i = 0; i < 256; i++) begin
      look(8'(i), v);
      if (v !== ((i == 255) ? 24'hFFFFFF : 24'h0)) begin
        errs++;
        check("R1", {8'h0, v}, (i == 255) ? 32'hFFFFFF : 32'h0);
      end
    end
    check("R1 sweep", 0, 0);
    check("R6 idle rvalid", {31'h0, bus_rvalid}, 0);

    // R6: read response
    @(negedge clk); bus_rd = 1'b1; bus_addr = 4'h4; bus_be = 4'hF;
    @(negedge clk); bus_rd = 1'b0;
    check("R6 rvalid", {31'h0, bus_rvalid}, 1);
    check("R6 rdata", bus_rdata, 0);
    @(negedge clk);
    check("R6 single pulse", {31'h0, bus_rvalid}, 0);
    @(negedge clk); bus_rd = 1'b1; bus_be = 4'h3;
    @(negedge clk); bus_rd = 1'b0; bus_be = 4'hF;
    check("R5 R6 rejected read", {31'h0, bus_rvalid}, 0);

    // R3 R4: stream the whole table with junk in the low bits
    wr(4'h0, 32'h00_ABCDEF, 4'hF);
    for (int i = 0; i < 256; i++) begin
      wr(4'h4, {fr(i), 24'h123456}, 4'hF);
      wr(4'h4, {fg(i), 24'hFEDCBA}, 4'hF);
      wr(4'h4, {fb(i), 24'h0F0F0F}, 4'hF);
    end
    errs = 0;
    for (int i = 0; i < 256; i++) begin
      look(8'(i), v);
      if (i != 255) begin
        if (v !== {fr(i), fg(i), fb(i)}) errs++;
        if (v !== {fr(i), fg(i), fb(i)}) check("R7 R3 R4 stream", {8'h0, v}, {8'h0, fr(i), fg(i), fb(i)});
      end else begin
        check("R7 R3 R4 entry 255", {8'h0, v}, {8'h0, fr(i), fg(i), fb(i)});
      end
    end
    check("R7 stream sweep", errs, 0);

    // R10: index wrapped to 0
    wr(4'h4, 32'hA1_000000, 4'hF);
    wr(4'h4, 32'hA2_000000, 4'hF);
    wr(4'h4, 32'hA3_000000, 4'hF);
    look(8'd0, v);
    check("R10 wrap to entry 0", {8'h0, v}, 32'hA1A2A3);
    look(8'd1, v);
    check("R10 entry 1 untouched", {8'h0, v}, {8'h0, fr(1), fg(1), fb(1)});

    // R5: rejected writes change nothing
    wr(4'h0, 32'h20_000000, 4'hF);
    wr(4'h4, 32'h11_000000, 4'hF);
    wr(4'h4, 32'h99_000000, 4'h7);
    wr(4'h6, 32'h98_000000, 4'hF);
    wr(4'h8, 32'h97_000000, 4'hF);
    wr(4'hC, 32'h96_000000, 4'hF);
    wr(4'h1, 32'h40_000000, 4'hF);
    wr(4'h4, 32'h22_000000, 4'hF);
    wr(4'h4, 32'h33_000000, 4'hF);
    look(8'h20, v);
    check("R5 ignored writes", {8'h0, v}, 32'h112233);
    look(8'h40, v);
    check("R5 misaligned index ignored", {8'h0, v}, {8'h0, fr(8'h40), fg(8'h40), fb(8'h40)});
    wr(4'h4, 32'h55_000000, 4'hF);
    look(8'h21, v);
    check("R4 next entry after ignored", {8'h0, v}, {8'h0, 8'h55, fg(8'h21), fb(8'h21)});

    // R2: index write abandons a half-written triple
    wr(4'h0, 32'h30_000000, 4'hF);
    wr(4'h4, 32'h44_000000, 4'hF);
    wr(4'h0, 32'h31_000000, 4'hF);
    wr(4'h4, 32'h61_000000, 4'hF);
    wr(4'h4, 32'h62_000000, 4'hF);
    wr(4'h4, 32'h63_000000, 4'hF);
    look(8'h31, v);
    check("R2 phase back to red", {8'h0, v}, 32'h616263);
    look(8'h30, v);
    check("R2 R8 partial entry", {8'h0, v}, {8'h0, 8'h44, fg(8'h30), fb(8'h30)});

    // R8: partial writes after a fresh reset
    do_reset();
    wr(4'h0, 32'hFF_000000, 4'hF);
    wr(4'h4, 32'h12_000000, 4'hF);
    look(8'hFF, v);
    check("R8 entry 255 red only", {8'h0, v}, 32'h12FFFF);
    look(8'hFE, v);
    check("R8 R1 entry 254 after reset", {8'h0, v}, 0);
    wr(4'h0, 32'h0A_000000, 4'hF);
    wr(4'h4, 32'h77_000000, 4'hF);
    look(8'h0A, v);
    check("R8 entry 10 red only", {8'h0, v}, 32'h770000);

    // R9: lookup during the blue write
    wr(4'h0, 32'h05_000000, 4'hF);
    wr(4'h4, 32'h01_000000, 4'hF);
    wr(4'h4, 32'h02_000000, 4'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h03_000000; bus_be = 4'hF;
    lk_idx = 8'h05;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 old value in write cycle", {8'h0, lk_rgb}, 32'h010200);
    @(negedge clk);
    check("R9 new value next cycle", {8'h0, lk_rgb}, 32'h010203);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule